// File: doc/BRIEF.md
# NIC command and interrupt register bank

This block is the host-visible control bank of a network controller. A word-wide write strobe with a 6-bit word index and 16-bit data updates a 64-entry bank of 16-bit registers. Reads are combinational on the same index. Three registers carry behaviour:

- **Command register.** Each bit starts or stops a controller action. Writing a bit launches the action as a one-cycle pulse on a dedicated output. The transmit, resource-read and CAM-load bits then stay set until the engine that performs the action reports completion.
- **Interrupt status register.** Completion and event inputs set its bits. The host clears bits by writing ones to them.
- **Interrupt mask register.** It gates the status bits onto a single level interrupt output.

The remaining registers follow fixed write rules chosen by index:

- masking of unused bits;
- write-protection of the configuration registers unless a software reset is pending;
- inversion of written values for the tally counters;
- read-only entries.

DMA engines, the timer counter and packet handling live outside the block. Each of them sees only its start pulse and drives back a done or event input.

Top module: `nic_cmd_regs`

## Requirements
- R1: After the asynchronous reset:
  - the command register (index 0x00) reads 0x0094, which is the reset, stop-timer and receiver-disable bits;
  - index 0x13 reads 0x02F8;
  - index 0x28 reads 0x0004;
  - every other index reads 0;
  - the interrupt is low and no action pulse is active.
- R2: An accepted write to index 0x00 ORs `wdata & 0x03BF` into the command register. The command bits are:
  - bit 0: halt;
  - bit 1: transmit;
  - bit 2: receiver disable;
  - bit 3: receiver enable;
  - bit 4: timer stop;
  - bit 5: timer start;
  - bit 7: reset;
  - bit 8: resource read;
  - bit 9: CAM load.

  Bits 1, 2, 3, 4, 5, 7, 8 and 9 each raise their own action output for exactly the cycle after the write. The halt bit has no pulse.
- R3: In an accepted command write, receiver disable clears the stored receiver-enable bit and receiver enable clears the stored receiver-disable bit. Writing both leaves both cleared. The timer stop and timer start bits behave the same way towards each other.
- R4: While command bit 7 is set, a write to index 0x00 whose bit 7 is 0 only clears bit 7. No other bit changes and no pulse is issued.
- R5: An accepted command write with bit 7 set:
  - clears bits 0, 1, 8 and 9;
  - sets bits 7 and 2;
  - suppresses the transmit, resource-read and CAM-load pulses of that write.
- R6: Completion inputs clear command bits and set status bits in the same cycle:
  - transmit-done clears command bit 1 and sets status bit 9;
  - CAM-done clears command bit 9 and sets status bit 12;
  - resource-done clears command bit 8.

  A command write that sets the same bit in the same cycle wins over the completion.
- R7: A write to the status register (index 0x05) clears only those written-one bits that are currently set. Bits of the 16-bit event input set status bits. When a set and a clear hit the same bit in the same cycle, the set wins.
- R8: Clearing status bit 5 through a status write sets command bit 8 and raises the resource-read pulse in the next cycle.
- R9: The interrupt output is high exactly when `mask & status` is nonzero. The mask register is at index 0x04, and its bit 15 is never stored.
- R10: Index 0x01 stores `wdata & 0xBFFF` and index 0x3F stores `wdata & 0xF017`, but only while command bit 7 is set. At other times writes to these indices are ignored.
- R11: Index 0x03 stores only bits 15:12 of a write. Index 0x02 stores only bits 15:5.
- R12: Indices 0x2C, 0x2D and 0x2E store the bitwise inverse of the written value.
- R13: Writes to indices 0x22, 0x23, 0x24, 0x28 and 0x2F are ignored.
- R14: Every other index stores the written value unchanged and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe for the indexed register |
| addr_i | input | 6 | Register word index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data of the indexed register |
| evt_i | input | 16 | Event bits that set status bits |
| tx_done_i | input | 1 | Transmit completion |
| rsrc_done_i | input | 1 | Resource read completion |
| cam_done_i | input | 1 | CAM load completion |
| tx_go_o | output | 1 | Transmit start pulse |
| rx_dis_o | output | 1 | Receiver disable pulse |
| rx_en_o | output | 1 | Receiver enable pulse |
| tmr_stop_o | output | 1 | Timer stop pulse |
| tmr_start_o | output | 1 | Timer start pulse |
| sw_rst_o | output | 1 | Software reset pulse |
| rsrc_rd_o | output | 1 | Resource read pulse |
| cam_ld_o | output | 1 | CAM load pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data depends only on the index and the stored state, so it is due in the same cycle the index is presented. The bench drives the index on the falling edge and compares read data shortly afterwards, before the rising edge. Every write, completion and event takes effect at the next rising edge. The register contents, the one-cycle action pulses and the interrupt level all change together on that edge, because the interrupt is formed from registered mask and status. The bench therefore advances its behavioural model at the same edge and compares pulses and interrupt 1 ns after it. It also compares read data of the index driven in every cycle.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int NREG   = 1 << ADDR_W;

  // register indices whose behaviour depends on the index
  localparam logic [ADDR_W-1:0] IDX_CMD   = 6'h00;
  localparam logic [ADDR_W-1:0] IDX_CFG   = 6'h01;
  localparam logic [ADDR_W-1:0] IDX_RXC   = 6'h02;
  localparam logic [ADDR_W-1:0] IDX_TXC   = 6'h03;
  localparam logic [ADDR_W-1:0] IDX_IMR   = 6'h04;
  localparam logic [ADDR_W-1:0] IDX_ISR   = 6'h05;
  localparam logic [ADDR_W-1:0] IDX_EOB   = 6'h13;
  localparam logic [ADDR_W-1:0] IDX_CAMP2 = 6'h22;
  localparam logic [ADDR_W-1:0] IDX_CAMP1 = 6'h23;
  localparam logic [ADDR_W-1:0] IDX_CAMP0 = 6'h24;
  localparam logic [ADDR_W-1:0] IDX_REV   = 6'h28;
  localparam logic [ADDR_W-1:0] IDX_TAL0  = 6'h2C;
  localparam logic [ADDR_W-1:0] IDX_TAL1  = 6'h2D;
  localparam logic [ADDR_W-1:0] IDX_TAL2  = 6'h2E;
  localparam logic [ADDR_W-1:0] IDX_RO2F  = 6'h2F;
  localparam logic [ADDR_W-1:0] IDX_CFG2  = 6'h3F;

  localparam logic [DATA_W-1:0] CMD_MASK  = 16'h03BF;
  localparam logic [DATA_W-1:0] CMD_RST_V = 16'h0094;
  localparam logic [DATA_W-1:0] IMR_MASK  = 16'h7FFF;
  localparam logic [DATA_W-1:0] CFG_MASK  = 16'hBFFF;
  localparam logic [DATA_W-1:0] CFG2_MASK = 16'hF017;
  localparam logic [DATA_W-1:0] TXC_MASK  = 16'hF000;
  localparam logic [DATA_W-1:0] RXC_MASK  = 16'hFFE0;
  localparam logic [DATA_W-1:0] EOB_RST_V = 16'h02F8;
  localparam logic [DATA_W-1:0] REV_RST_V = 16'h0004;

  // command bit positions
  localparam int B_HALT  = 0;
  localparam int B_TX    = 1;
  localparam int B_RXDIS = 2;
  localparam int B_RXEN  = 3;
  localparam int B_TSTOP = 4;
  localparam int B_TSTRT = 5;
  localparam int B_RST   = 7;
  localparam int B_RSRC  = 8;
  localparam int B_CAM   = 9;

  // status bit positions
  localparam int S_RBE  = 5;
  localparam int S_TXDN = 9;
  localparam int S_LCD  = 12;

  typedef struct packed {
    logic tx;
    logic rx_dis;
    logic rx_en;
    logic tmr_stop;
    logic tmr_start;
    logic sw_rst;
    logic rsrc;
    logic cam;
  } act_t;

  // {enable, value} for a plain-bank write
  function automatic logic [DATA_W:0] store_rule(input logic [ADDR_W-1:0] idx,
                                                 input logic [DATA_W-1:0] w,
                                                 input logic rst_pend);
    logic [DATA_W:0] r;
    case (idx)
      IDX_CFG:  r = {rst_pend, w & CFG_MASK};
      IDX_CFG2: r = {rst_pend, w & CFG2_MASK};
      IDX_TXC:  r = {1'b1, w & TXC_MASK};
      IDX_RXC:  r = {1'b1, w & RXC_MASK};
      IDX_TAL0, IDX_TAL1, IDX_TAL2: r = {1'b1, ~w};
      IDX_CAMP2, IDX_CAMP1, IDX_CAMP0, IDX_REV, IDX_RO2F,
      IDX_CMD, IDX_IMR, IDX_ISR: r = {1'b0, w};
      default:  r = {1'b1, w};
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] reset_val(input logic [ADDR_W-1:0] idx);
    case (idx)
      IDX_EOB: return EOB_RST_V;
      IDX_REV: return REV_RST_V;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/nic_reg_store.sv
module nic_reg_store
  import nic_cmd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  localparam int NE = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rst_pend_i,
  output logic [DW-1:0] rdata_o
);
  logic [NE*DW-1:0] flat;

  for (genvar gi = 0; gi < NE; gi++) begin : g_ent
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(gi);
    logic [DW-1:0] ent_q;
    logic [DW:0]   rule;
    logic          hit;

    always_comb begin
      hit  = we_i && (addr_i == AW'(gi));
      rule = store_rule(IDX, wdata_i, rst_pend_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              ent_q <= reset_val(IDX);
      else if (hit && rule[DW]) ent_q <= rule[DW-1:0];
    end

    assign flat[gi*DW +: DW] = ent_q;
  end

  assign rdata_o = flat[addr_i*DW +: DW];
endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_cmd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tx_done_i,
  input  logic          rsrc_done_i,
  input  logic          cam_done_i,
  input  logic          rbe_clr_i,
  output logic [DW-1:0] cmd_o,
  output act_t          act_o
);
  logic [DW-1:0] cmd_q, cmd_d;
  act_t          act_d, act_q;
  logic          swallow;

  always_comb begin
    cmd_d = cmd_q;
    act_d = '0;
    if (tx_done_i)   cmd_d[B_TX]   = 1'b0;
    if (rsrc_done_i) cmd_d[B_RSRC] = 1'b0;
    if (cam_done_i)  cmd_d[B_CAM]  = 1'b0;
    swallow = cmd_we_i && cmd_q[B_RST] && !wdata_i[B_RST];
    if (swallow) begin
      cmd_d[B_RST] = 1'b0;
    end else if (cmd_we_i) begin
      cmd_d = cmd_d | (wdata_i & CMD_MASK);
      if (wdata_i[B_RXDIS]) cmd_d[B_RXEN]  = 1'b0;
      if (wdata_i[B_RXEN])  cmd_d[B_RXDIS] = 1'b0;
      if (wdata_i[B_TSTOP]) cmd_d[B_TSTRT] = 1'b0;
      if (wdata_i[B_TSTRT]) cmd_d[B_TSTOP] = 1'b0;
      if (wdata_i[B_RST]) begin
        cmd_d[B_CAM]   = 1'b0;
        cmd_d[B_RSRC]  = 1'b0;
        cmd_d[B_TX]    = 1'b0;
        cmd_d[B_HALT]  = 1'b0;
        cmd_d[B_RST]   = 1'b1;
        cmd_d[B_RXDIS] = 1'b1;
      end
      act_d.tx        = wdata_i[B_TX] && !wdata_i[B_RST];
      act_d.rx_dis    = wdata_i[B_RXDIS];
      act_d.rx_en     = wdata_i[B_RXEN];
      act_d.tmr_stop  = wdata_i[B_TSTOP];
      act_d.tmr_start = wdata_i[B_TSTRT];
      act_d.sw_rst    = wdata_i[B_RST];
      act_d.rsrc      = wdata_i[B_RSRC] && !wdata_i[B_RST];
      act_d.cam       = wdata_i[B_CAM] && !wdata_i[B_RST];
    end
    // status-driven resource read (never coincides with a command write)
    if (rbe_clr_i) begin
      cmd_d[B_RSRC] = 1'b1;
      act_d.rsrc    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_RST_V;
      act_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      act_q <= act_d;
    end
  end

  assign cmd_o = cmd_q;
  assign act_o = act_q;
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_cmd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          imr_we_i,
  input  logic          isr_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] evt_i,
  input  logic          tx_done_i,
  input  logic          cam_done_i,
  output logic [DW-1:0] imr_o,
  output logic [DW-1:0] isr_o,
  output logic          rbe_clr_o,
  output logic          irq_o
);
  logic [DW-1:0] imr_q, isr_q, set_v, clr_v;

  always_comb begin
    set_v         = evt_i;
    set_v[S_TXDN] = set_v[S_TXDN] | tx_done_i;
    set_v[S_LCD]  = set_v[S_LCD]  | cam_done_i;
    clr_v         = isr_we_i ? (wdata_i & isr_q) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q <= '0;
      isr_q <= '0;
    end else begin
      if (imr_we_i) imr_q <= wdata_i & IMR_MASK;
      isr_q <= (isr_q & ~clr_v) | set_v;  // set beats clear
    end
  end

  assign rbe_clr_o = clr_v[S_RBE];
  assign irq_o     = |(imr_q & isr_q);
  assign imr_o     = imr_q;
  assign isr_o     = isr_q;
endmodule

// File: rtl/nic_cmd_regs.sv
module nic_cmd_regs
  import nic_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              tx_done_i,
  input  logic              rsrc_done_i,
  input  logic              cam_done_i,
  output logic              tx_go_o,
  output logic              rx_dis_o,
  output logic              rx_en_o,
  output logic              tmr_stop_o,
  output logic              tmr_start_o,
  output logic              sw_rst_o,
  output logic              rsrc_rd_o,
  output logic              cam_ld_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cmd_q, imr_q, isr_q, bank_rd;
  logic              rbe_clr;
  act_t              act;

  nic_cmd_ctrl u_cmd (
    .clk_i, .rst_ni,
    .cmd_we_i   (we_i && addr_i == IDX_CMD),
    .wdata_i,
    .tx_done_i, .rsrc_done_i, .cam_done_i,
    .rbe_clr_i  (rbe_clr),
    .cmd_o      (cmd_q),
    .act_o      (act)
  );

  nic_irq_ctrl u_irq (
    .clk_i, .rst_ni,
    .imr_we_i   (we_i && addr_i == IDX_IMR),
    .isr_we_i   (we_i && addr_i == IDX_ISR),
    .wdata_i, .evt_i, .tx_done_i, .cam_done_i,
    .imr_o      (imr_q),
    .isr_o      (isr_q),
    .rbe_clr_o  (rbe_clr),
    .irq_o
  );

  nic_reg_store u_bank (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .rst_pend_i (cmd_q[B_RST]),
    .rdata_o    (bank_rd)
  );

  always_comb begin
    case (addr_i)
      IDX_CMD: rdata_o = cmd_q;
      IDX_IMR: rdata_o = imr_q;
      IDX_ISR: rdata_o = isr_q;
      default: rdata_o = bank_rd;
    endcase
  end

  assign tx_go_o     = act.tx;
  assign rx_dis_o    = act.rx_dis;
  assign rx_en_o     = act.rx_en;
  assign tmr_stop_o  = act.tmr_stop;
  assign tmr_start_o = act.tmr_start;
  assign sw_rst_o    = act.sw_rst;
  assign rsrc_rd_o   = act.rsrc;
  assign cam_ld_o    = act.cam;
endmodule

// File: rtl/nic_cmd_regs_chk.sv
module nic_cmd_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic [5:0]  addr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] evt_i,
  input logic        tx_done_i,
  input logic        cam_done_i,
  input logic        tx_go_o,
  input logic        rx_dis_o,
  input logic        rx_en_o,
  input logic        tmr_stop_o,
  input logic        tmr_start_o,
  input logic        sw_rst_o,
  input logic        rsrc_rd_o,
  input logic        cam_ld_o,
  input logic        irq_o,
  input logic [15:0] cmd_q,
  input logic [15:0] imr_q,
  input logic [15:0] isr_q
);
  // R4
  swallow_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 6'h00 && cmd_q[7] && !wdata_i[7]) |=>
      (!cmd_q[7] && !tx_go_o && !rx_dis_o && !rx_en_o && !tmr_stop_o &&
       !tmr_start_o && !sw_rst_o && !rsrc_rd_o && !cam_ld_o));

  // R2
  tx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 6'h00 && wdata_i[1] && !wdata_i[7] && !cmd_q[7]) |=>
      (tx_go_o && cmd_q[1]));

  // R6
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q[1] && !tx_done_i && !(we_i && addr_i == 6'h00 && wdata_i[7])) |=> cmd_q[1]);

  // R7
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((isr_q & $past(evt_i)) == $past(evt_i)));

  // R7
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 6'h05 && evt_i == 16'h0 && !tx_done_i && !cam_done_i) |=>
      ((isr_q & $past(wdata_i & isr_q)) == 16'h0));

  // R9
  irq_txdn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && imr_q[9] && !(we_i && addr_i == 6'h04)) |=> irq_o);

  // R9
  imr_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 6'h04) |=> !imr_q[15]);
endmodule

bind nic_cmd_regs nic_cmd_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .evt_i(evt_i), .tx_done_i(tx_done_i), .cam_done_i(cam_done_i),
  .tx_go_o(tx_go_o), .rx_dis_o(rx_dis_o), .rx_en_o(rx_en_o),
  .tmr_stop_o(tmr_stop_o), .tmr_start_o(tmr_start_o), .sw_rst_o(sw_rst_o),
  .rsrc_rd_o(rsrc_rd_o), .cam_ld_o(cam_ld_o), .irq_o(irq_o),
  .cmd_q(cmd_q), .imr_q(imr_q), .isr_q(isr_q)
);

// File: tb/nic_cmd_regs_bench.sv
`timescale 1ns/1ps
module nic_cmd_regs_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] evt_i = '0;
  logic        tx_done_i = 1'b0, rsrc_done_i = 1'b0, cam_done_i = 1'b0;
  logic [15:0] rdata_o;
  logic tx_go_o, rx_dis_o, rx_en_o, tmr_stop_o, tmr_start_o, sw_rst_o, rsrc_rd_o, cam_ld_o, irq_o;

  always #5 clk = ~clk;

  nic_cmd_regs u_nic_cmd_regs (
    .clk_i(clk), .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .evt_i,
    .tx_done_i, .rsrc_done_i, .cam_done_i,
    .tx_go_o, .rx_dis_o, .rx_en_o, .tmr_stop_o, .tmr_start_o, .sw_rst_o,
    .rsrc_rd_o, .cam_ld_o, .irq_o
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state
  logic [15:0] m_cmd, m_imr, m_isr;
  logic [15:0] m_mem [64];
  logic [7:0]  m_act;  // {tx,rx_dis,rx_en,stop,start,rst,rsrc,cam}

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] m_read(logic [5:0] a);
    if (a == 6'h00) return m_cmd;
    if (a == 6'h04) return m_imr;
    if (a == 6'h05) return m_isr;
    return m_mem[a];
  endfunction

  function automatic logic [15:0] m_store(logic [5:0] a, logic [15:0] w, logic rp, logic [15:0] old);
    case (a)
      6'h01: return rp ? (w & 16'hBFFF) : old;
      6'h3F: return rp ? (w & 16'hF017) : old;
      6'h03: return w & 16'hF000;
      6'h02: return w & 16'hFFE0;
      6'h2C, 6'h2D, 6'h2E: return ~w;
      6'h22, 6'h23, 6'h24, 6'h28, 6'h2F: return old;
      default: return w;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 64; i++) m_mem[i] = 16'h0;
    m_mem[6'h13] = 16'h02F8;
    m_mem[6'h28] = 16'h0004;
    m_cmd = 16'h0094;
    m_imr = 16'h0;
    m_isr = 16'h0;
    m_act = 8'h0;
  endtask

  task automatic m_step();
    logic [15:0] c, clr;
    logic [7:0]  a;
    c = m_cmd;
    a = 8'h0;
    clr = 16'h0;
    if (tx_done_i)   c[1] = 1'b0;
    if (rsrc_done_i) c[8] = 1'b0;
    if (cam_done_i)  c[9] = 1'b0;
    if (we_i && addr_i == 6'h00) begin
      if (m_cmd[7] && !wdata_i[7]) c[7] = 1'b0;
      else begin
        c = c | (wdata_i & 16'h03BF);
        if (wdata_i[2]) c[3] = 1'b0;
        if (wdata_i[3]) c[2] = 1'b0;
        if (wdata_i[4]) c[5] = 1'b0;
        if (wdata_i[5]) c[4] = 1'b0;
        if (wdata_i[7]) begin
          c = c & ~16'h0303;
          c = c | 16'h0084;
        end
        a[7] = wdata_i[1] & ~wdata_i[7];
        a[6] = wdata_i[2];
        a[5] = wdata_i[3];
        a[4] = wdata_i[4];
        a[3] = wdata_i[5];
        a[2] = wdata_i[7];
        a[1] = wdata_i[8] & ~wdata_i[7];
        a[0] = wdata_i[9] & ~wdata_i[7];
      end
    end
    if (we_i && addr_i == 6'h05) clr = wdata_i & m_isr;
    if (clr[5]) begin c[8] = 1'b1; a[1] = 1'b1; end
    if (we_i && addr_i == 6'h04) m_imr = wdata_i & 16'h7FFF;
    if (we_i && addr_i != 6'h00 && addr_i != 6'h04 && addr_i != 6'h05)
      m_mem[addr_i] = m_store(addr_i, wdata_i, m_cmd[7], m_mem[addr_i]);
    m_isr = (m_isr & ~clr) | evt_i | (16'(tx_done_i) << 9) | (16'(cam_done_i) << 12);
    m_cmd = c;
    m_act = a;
  endtask

  // one clock: drive on falling edge, check read data, advance, check pulses and irq
  task automatic tick(string tag, logic we, logic [5:0] a, logic [15:0] w,
                      logic [15:0] ev = 16'h0, logic txd = 0, logic rrd = 0, logic camd = 0);
    @(negedge clk);
    we_i = we; addr_i = a; wdata_i = w; evt_i = ev;
    tx_done_i = txd; rsrc_done_i = rrd; cam_done_i = camd;
    #1;
    chk({tag, " rdata"}, rdata_o, m_read(a));
    m_step();
    @(posedge clk);
    #1;
    chk({tag, " pulses"}, {8'h0, tx_go_o, rx_dis_o, rx_en_o, tmr_stop_o, tmr_start_o,
                           sw_rst_o, rsrc_rd_o, cam_ld_o}, {8'h0, m_act});
    chk({tag, " irq"}, {15'h0, irq_o}, {15'h0, |(m_imr & m_isr)});
  endtask

  task automatic wr(string tag, logic [5:0] a, logic [15:0] w);
    tick(tag, 1'b1, a, w);
  endtask

  task automatic rd(string tag, logic [5:0] a);
    tick(tag, 1'b0, a, 16'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0] pool [11];
    pool = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h13, 6'h2C, 6'h22, 6'h30, 6'h3F};
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq at reset", {15'h0, irq_o}, 16'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset values
    rd("R1 cmd", 6'h00);
    rd("R1 eob", 6'h13);
    rd("R1 rev", 6'h28);
    rd("R1 isr", 6'h05);
    rd("R1 plain", 6'h10);

    // R10 config writes allowed while reset pending
    wr("R10 cfg", 6'h01, 16'hFFFF);
    rd("R10 cfg read", 6'h01);
    wr("R10 cfg2", 6'h3F, 16'hFFFF);
    rd("R10 cfg2 read", 6'h3F);

    // R4 reset pending swallows a write without bit 7
    wr("R4 swallow", 6'h00, 16'h0002);
    rd("R4 cmd after", 6'h00);
    chk("R4 cmd value", rdata_o, 16'h0014);

    // R10 writes now ignored
    wr("R10 cfg blocked", 6'h01, 16'h1234);
    rd("R10 cfg kept", 6'h01);
    chk("R10 cfg value", rdata_o, 16'hBFFF);

    // R9 mask bit 15 not stored
    wr("R9 imr", 6'h04, 16'hFFFF);
    rd("R9 imr read", 6'h04);
    chk("R9 imr value", rdata_o, 16'h7FFF);
    wr("R9 imr txdn", 6'h04, 16'h0200);

    // R2 transmit launch with unstored bits
    wr("R2 tx launch", 6'h00, 16'hFC42);
    rd("R2 cmd", 6'h00);
    chk("R2 cmd value", rdata_o, 16'h0016);
    rd("R2 tx held", 6'h00);

    // R6 transmit completion, R9 irq rises
    tick("R6 tx done", 1'b0, 6'h00, 16'h0, 16'h0, 1'b1);
    chk("R9 irq high", {15'h0, irq_o}, 16'h0001);
    rd("R6 isr", 6'h05);
    chk("R6 isr value", rdata_o, 16'h0200);

    // R7 w1c, only set bits
    wr("R7 w1c", 6'h05, 16'hFFFF);
    rd("R7 isr cleared", 6'h05);
    chk("R7 isr zero", rdata_o, 16'h0000);
    tick("R7 evt", 1'b0, 6'h05, 16'h0, 16'h0008);
    tick("R7 set wins", 1'b1, 6'h05, 16'h0008, 16'h0008);
    rd("R7 isr kept", 6'h05);
    chk("R7 bit3 value", rdata_o, 16'h0008);

    // R9 bit 15 of status cannot raise irq
    wr("R9 imr all", 6'h04, 16'hFFFF);
    wr("R9 clr", 6'h05, 16'h0008);
    tick("R9 evt15", 1'b0, 6'h05, 16'h0, 16'h8000);
    chk("R9 irq low", {15'h0, irq_o}, 16'h0000);

    // R8 clearing buffers-exhausted triggers resource read
    tick("R8 rbe", 1'b0, 6'h05, 16'h0, 16'h0020);
    wr("R8 rbe clr", 6'h05, 16'h0020);
    chk("R8 rsrc pulse", {15'h0, rsrc_rd_o}, 16'h0001);
    rd("R8 cmd", 6'h00);
    chk("R8 bit8", rdata_o & 16'h0100, 16'h0100);
    tick("R6 rsrc done", 1'b0, 6'h00, 16'h0, 16'h0, 1'b0, 1'b1);
    rd("R6 rsrc cleared", 6'h00);

    // R3 mutual clears
    wr("R3 rx en", 6'h00, 16'h0008);
    rd("R3 cmd", 6'h00);
    chk("R3 rx en value", rdata_o & 16'h000C, 16'h0008);
    wr("R3 tmr start", 6'h00, 16'h0020);
    rd("R3 cmd2", 6'h00);
    chk("R3 timer value", rdata_o & 16'h0030, 16'h0020);
    wr("R3 both rx", 6'h00, 16'h000C);
    rd("R3 cmd3", 6'h00);
    chk("R3 both cleared", rdata_o & 16'h000C, 16'h0000);

    // R6 host set wins over completion; CAM completion
    tick("R6 tx vs done", 1'b1, 6'h00, 16'h0002, 16'h0, 1'b1);
    rd("R6 cmd", 6'h00);
    chk("R6 tx kept", rdata_o & 16'h0002, 16'h0002);
    wr("R6 cam", 6'h00, 16'h0200);
    tick("R6 cam done", 1'b0, 6'h05, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1);
    rd("R6 isr cam", 6'h05);
    chk("R6 lcd bit", rdata_o & 16'h1000, 16'h1000);

    // R5 software reset cancels pending actions
    wr("R5 pending", 6'h00, 16'h0301);
    wr("R5 reset", 6'h00, 16'h0382);
    chk("R5 only reset pulse", {8'h0, tx_go_o, rx_dis_o, rx_en_o, tmr_stop_o, tmr_start_o,
                                 sw_rst_o, rsrc_rd_o, cam_ld_o}, 16'h0004);
    rd("R5 cmd", 6'h00);
    chk("R5 cmd bits", rdata_o & 16'h0387, 16'h0084);
    wr("R4 leave reset", 6'h00, 16'h0000);

    // R11 masks
    wr("R11 txc", 6'h03, 16'hFFFF);
    rd("R11 txc read", 6'h03);
    chk("R11 txc value", rdata_o, 16'hF000);
    wr("R11 rxc", 6'h02, 16'hFFFF);
    rd("R11 rxc read", 6'h02);
    chk("R11 rxc value", rdata_o, 16'hFFE0);

    // R12 tally inversion
    wr("R12 tally", 6'h2D, 16'h1234);
    rd("R12 tally read", 6'h2D);
    chk("R12 tally value", rdata_o, 16'hEDCB);

    // R13 read-only
    wr("R13 cam port", 6'h22, 16'hFFFF);
    rd("R13 cam port read", 6'h22);
    chk("R13 cam port value", rdata_o, 16'h0000);
    wr("R13 rev", 6'h28, 16'hFFFF);
    rd("R13 rev read", 6'h28);
    chk("R13 rev value", rdata_o, 16'h0004);
    wr("R13 2f", 6'h2F, 16'h5555);
    rd("R13 2f read", 6'h2F);

    // R14 plain storage
    wr("R14 plain", 6'h30, 16'hA5A5);
    rd("R14 plain read", 6'h30);
    chk("R14 plain value", rdata_o, 16'hA5A5);
    rd("R14 untouched", 6'h31);

    // mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [15:0] ev;
      ev = ($urandom_range(3) == 0) ? (16'h1 << $urandom_range(15)) : 16'h0;
      tick("R2 R7 mixed", ($urandom_range(2) == 0), pool[$urandom_range(10)],
           16'($urandom), ev, ($urandom_range(7) == 0), ($urandom_range(7) == 0),
           ($urandom_range(7) == 0));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule